// File: doc/BRIEF.md
# Electrochromic Charge-Path Fault Supervisor

This block watches the high-side switch that feeds an electrochromic element while the element is being charged. The protections apply only in one case: EC control is enabled, the switch is selected as the EC supply, and the element is in its charge (ramp-up) phase. In that case an overcurrent, or an overtemperature in one of the shutdown zones, turns the EC regulation loop off and locks it off.

Clearing the fault is not enough to unlock it. The loop restarts only after two events have both happened, in either order:

- a clear strobe has been accepted, which requires the fault condition to be gone when the strobe arrives;
- a new target voltage has been written.

The block also keeps four sticky status bits. It blocks PWM operation of the switch whenever that switch serves as the EC supply.

Top module: `ecc_fault_sup`

## Requirements
- R1: After reset, `loop_en_o` is 0 and all `st_o` bits are 0.
- R2: With `ec_en_i` high and no lock pending, `loop_en_o` is 1 from the first clock edge after `ec_en_i` is sampled high.
- R3: A trip turns `loop_en_o` to 0 at the next edge and locks the loop. A trip is `oc_i` high, or `ot_zone_i` of 3 or more, in a cycle where `ec_en_i`, `hs_supply_i` and `charge_i` are all high.
- R4: When `hs_supply_i` or `charge_i` is low, `oc_i`, `ot_zone_i` and `ol_i` neither trip the loop nor set any status bit.
- R5: A locked loop re-enables at the edge that samples the second of the two restart events. The events are an accepted clear and a target write, in either order or both in the same cycle. Either event on its own keeps the loop off.
- R6: A trip in the same cycle as a restart event wins: the loop stays locked and any restart event already seen is discarded.
- R7: A clear strobe is ignored while the condition behind a status bit is still present; that bit stays set. While a trip condition is present, the clear also does not count as a restart event.
- R8: Overtemperature zones 1 and 2 while protections are active set `st_o[2]` and leave `loop_en_o` unchanged. Bit positions of `st_o`: [0] overcurrent, [1] overtemperature shutdown (zone 3 or more), [2] overtemperature warning, [3] open load.
- R9: An open load during active protection sets `st_o[3]` and does not affect `loop_en_o`.
- R10: A status bit stays set after its condition goes away, until a clear strobe arrives while the condition is absent.
- R11: `pwm_en_o` equals `pwm_req_i` when `hs_supply_i` is 0, and is 0 whenever `hs_supply_i` is 1. This is combinational.
- R12: While `ec_en_i` is low, `loop_en_o` is 0 from the next edge and any lock and restart events are discarded. Re-enabling then restarts the loop with no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ec_en_i | input | 1 | EC control enable |
| hs_supply_i | input | 1 | 1 = EC powered through the high-side switch |
| charge_i | input | 1 | 1 = charge (ramp-up) phase, 0 = discharge |
| oc_i | input | 1 | Overcurrent flag from the switch |
| ot_zone_i | input | ZONE_W (3) | Overtemperature zone, 0 = none |
| ol_i | input | 1 | Open-load flag from the switch |
| pwm_req_i | input | 1 | Request to run the switch in PWM mode |
| clr_i | input | 1 | Read-and-clear strobe for faults |
| tgt_wr_i | input | 1 | Target-voltage write strobe |
| loop_en_o | output | 1 | Regulation loop enable |
| pwm_en_o | output | 1 | PWM mode permitted |
| st_o | output | 4 | Sticky status bits (see R8) |

## Verification
Three events can meet in one cycle: a new trip, a clear strobe and a target write. The bench provokes this in two ways.

- After an accepted clear, it raises `oc_i` in the same cycle as `tgt_wr_i`. It then expects the loop to stay off and a lone target write to be insufficient afterwards.
- It also issues the clear and the target write together in a single cycle with no fault present. It expects `loop_en_o` to be high right after that edge.

A separate sequence strobes a clear while the overcurrent is still present. It then judges, through `st_o[0]` and through whether a following lone target write restarts the loop, that the clear was ignored.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    // status bit positions
    localparam int ST_OC  = 0;
    localparam int ST_OTS = 1;
    localparam int ST_OTW = 2;
    localparam int ST_OL  = 3;
    localparam int ST_N   = 4;

    typedef struct packed {
        logic locked;
        logic clr_seen;
        logic tgt_seen;
        logic loop_en;
    } restart_t;

endpackage

// File: rtl/ecc_cond.sv
module ecc_cond #(
    parameter int ZONE_W    = 3,
    parameter int TRIP_ZONE = 3
) (
    input  logic              ec_en_i,
    input  logic              hs_supply_i,
    input  logic              charge_i,
    input  logic              oc_i,
    input  logic [ZONE_W-1:0] ot_zone_i,
    input  logic              ol_i,
    input  logic              pwm_req_i,
    output logic              trip_o,
    output logic [ecc_pkg::ST_N-1:0] raw_o,
    output logic              pwm_en_o
);
    import ecc_pkg::*;

    localparam logic [ZONE_W-1:0] TRIP_Z = ZONE_W'(TRIP_ZONE);

    logic active;
    logic ot_shut;
    logic ot_warn;

    always_comb begin
        active  = ec_en_i & hs_supply_i & charge_i;
        ot_shut = (ot_zone_i >= TRIP_Z);
        ot_warn = (ot_zone_i != '0) & ~ot_shut;

        raw_o         = '0;
        raw_o[ST_OC]  = active & oc_i;
        raw_o[ST_OTS] = active & ot_shut;
        raw_o[ST_OTW] = active & ot_warn;
        raw_o[ST_OL]  = active & ol_i;

        trip_o   = raw_o[ST_OC] | raw_o[ST_OTS];
        pwm_en_o = pwm_req_i & ~hs_supply_i;
    end

endmodule

// File: rtl/ecc_sticky.sv
module ecc_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    input  logic         clr_i,
    output logic [N-1:0] st_o
);
    logic [N-1:0] st_d, st_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_comb begin
            if (raw_i[g])
                st_d[g] = 1'b1;
            else if (clr_i)
                st_d[g] = 1'b0;
            else
                st_d[g] = st_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign st_o = st_q;

endmodule

// File: rtl/ecc_restart.sv
module ecc_restart (
    input  logic clk,
    input  logic rst_n,
    input  logic ec_en_i,
    input  logic trip_i,
    input  logic clr_i,
    input  logic tgt_wr_i,
    output logic loop_en_o
);
    import ecc_pkg::*;

    restart_t s_d, s_q;
    logic     clr_ok;
    logic     clr_nxt;
    logic     tgt_nxt;

    always_comb begin
        s_d     = s_q;
        clr_ok  = clr_i & ~trip_i;
        clr_nxt = s_q.clr_seen | clr_ok;
        tgt_nxt = s_q.tgt_seen | tgt_wr_i;

        if (!ec_en_i) begin
            s_d = '0;
        end else if (trip_i) begin
            s_d.locked   = 1'b1;
            s_d.clr_seen = 1'b0;
            s_d.tgt_seen = 1'b0;
            s_d.loop_en  = 1'b0;
        end else if (s_q.locked) begin
            if (clr_nxt && tgt_nxt) begin
                s_d = '0;
                s_d.loop_en = 1'b1;
            end else begin
                s_d.clr_seen = clr_nxt;
                s_d.tgt_seen = tgt_nxt;
                s_d.loop_en  = 1'b0;
            end
        end else begin
            s_d.loop_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign loop_en_o = s_q.loop_en;

endmodule

// File: rtl/ecc_fault_sup.sv
module ecc_fault_sup #(
    parameter int ZONE_W    = 3,
    parameter int TRIP_ZONE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ec_en_i,
    input  logic              hs_supply_i,
    input  logic              charge_i,
    input  logic              oc_i,
    input  logic [ZONE_W-1:0] ot_zone_i,
    input  logic              ol_i,
    input  logic              pwm_req_i,
    input  logic              clr_i,
    input  logic              tgt_wr_i,
    output logic              loop_en_o,
    output logic              pwm_en_o,
    output logic [3:0]        st_o
);
    import ecc_pkg::*;

    logic            trip;
    logic [ST_N-1:0] raw;

    ecc_cond #(.ZONE_W(ZONE_W), .TRIP_ZONE(TRIP_ZONE)) cond_i (
        .ec_en_i    (ec_en_i),
        .hs_supply_i(hs_supply_i),
        .charge_i   (charge_i),
        .oc_i       (oc_i),
        .ot_zone_i  (ot_zone_i),
        .ol_i       (ol_i),
        .pwm_req_i  (pwm_req_i),
        .trip_o     (trip),
        .raw_o      (raw),
        .pwm_en_o   (pwm_en_o)
    );

    ecc_sticky #(.N(ST_N)) sticky_i (
        .clk  (clk),
        .rst_n(rst_n),
        .raw_i(raw),
        .clr_i(clr_i),
        .st_o (st_o)
    );

    ecc_restart restart_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ec_en_i  (ec_en_i),
        .trip_i   (trip),
        .clr_i    (clr_i),
        .tgt_wr_i (tgt_wr_i),
        .loop_en_o(loop_en_o)
    );

endmodule

// File: rtl/ecc_fault_sup_chk.sv
module ecc_fault_sup_chk #(
    parameter int ZONE_W    = 3,
    parameter int TRIP_ZONE = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ec_en_i,
    input logic              hs_supply_i,
    input logic              charge_i,
    input logic              oc_i,
    input logic [ZONE_W-1:0] ot_zone_i,
    input logic              ol_i,
    input logic              pwm_req_i,
    input logic              clr_i,
    input logic              tgt_wr_i,
    input logic              loop_en_o,
    input logic              pwm_en_o,
    input logic [3:0]        st_o
);
    localparam logic [ZONE_W-1:0] TZ = ZONE_W'(TRIP_ZONE);

    logic guard;
    logic hot;
    assign guard = ec_en_i & hs_supply_i & charge_i;
    assign hot   = oc_i | (ot_zone_i >= TZ);

    // R3
    p_trip_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (guard && hot) |=> !loop_en_o);

    // R12
    p_disable_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ec_en_i |=> !loop_en_o);

    // R11
    p_pwm_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hs_supply_i |-> !pwm_en_o);

    // R10
    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o[0] && !clr_i) |=> st_o[0]);

    // R7
    p_clr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (guard && oc_i && clr_i) |=> st_o[0]);

    // R4
    p_inactive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!hs_supply_i || !charge_i) && !st_o[0]) |=> !st_o[0]);

    // R8
    p_warn_keeps_loop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en_o && ec_en_i && !(guard && hot)) |=> loop_en_o);

    // R9
    p_ol_keeps_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (guard && ol_i && !hot) |=> st_o[3]);

endmodule

bind ecc_fault_sup ecc_fault_sup_chk #(.ZONE_W(ZONE_W), .TRIP_ZONE(TRIP_ZONE)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ec_en_i    (ec_en_i),
    .hs_supply_i(hs_supply_i),
    .charge_i   (charge_i),
    .oc_i       (oc_i),
    .ot_zone_i  (ot_zone_i),
    .ol_i       (ol_i),
    .pwm_req_i  (pwm_req_i),
    .clr_i      (clr_i),
    .tgt_wr_i   (tgt_wr_i),
    .loop_en_o  (loop_en_o),
    .pwm_en_o   (pwm_en_o),
    .st_o       (st_o)
);

// File: tb/ecc_fault_sup_tb.sv
`timescale 1ns/1ps
module ecc_fault_sup_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ec_en = 1'b0, hs = 1'b0, chg = 1'b0, oc = 1'b0, ol = 1'b0;
    logic [2:0] zone = 3'd0;
    logic       pwm_req = 1'b0, clr = 1'b0, tgt = 1'b0;
    logic       loop_en, pwm_en;
    logic [3:0] st;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ecc_fault_sup dut_i (
        .clk(clk), .rst_n(rst_n), .ec_en_i(ec_en), .hs_supply_i(hs),
        .charge_i(chg), .oc_i(oc), .ot_zone_i(zone), .ol_i(ol),
        .pwm_req_i(pwm_req), .clr_i(clr), .tgt_wr_i(tgt),
        .loop_en_o(loop_en), .pwm_en_o(pwm_en), .st_o(st)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        clr = 1'b0;
        tgt = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 loop", {7'd0, loop_en}, 8'd0);
        chk("R1 st", {4'd0, st}, 8'd0);
    endtask

    task automatic t_enable();
        ec_en = 1; hs = 1; chg = 1;
        cyc();
        chk("R2 loop on", {7'd0, loop_en}, 8'd1);
    endtask

    task automatic t_oc_clear_ignored();
        oc = 1; cyc();
        chk("R3 oc trip loop", {7'd0, loop_en}, 8'd0);
        chk("R3 oc st", {4'd0, st}, 8'h1);
        clr = 1; cyc();
        chk("R7 clr ignored st", {4'd0, st}, 8'h1);
        oc = 0; tgt = 1; cyc();
        chk("R7 clr not counted", {7'd0, loop_en}, 8'd0);
        chk("R10 sticky after cond gone", {4'd0, st}, 8'h1);
        clr = 1; cyc();
        chk("R5 tgt then clr restart", {7'd0, loop_en}, 8'd1);
        chk("R10 cleared", {4'd0, st}, 8'h0);
    endtask

    task automatic t_ot_clear_first();
        zone = 3'd4; cyc();
        chk("R3 ot trip loop", {7'd0, loop_en}, 8'd0);
        chk("R3 ot st", {4'd0, st}, 8'h2);
        zone = 3'd0; clr = 1; cyc();
        chk("R10 ot cleared", {4'd0, st}, 8'h0);
        cyc(); cyc();
        chk("R5 clear alone stays off", {7'd0, loop_en}, 8'd0);
        tgt = 1; cyc();
        chk("R5 clr then tgt restart", {7'd0, loop_en}, 8'd1);
    endtask

    task automatic t_same_cycle();
        oc = 1; cyc();
        oc = 0; cyc();
        chk("R5 locked", {7'd0, loop_en}, 8'd0);
        clr = 1; tgt = 1; cyc();
        chk("R5 both same cycle", {7'd0, loop_en}, 8'd1);
    endtask

    task automatic t_trip_vs_strobe();
        oc = 1; cyc();
        oc = 0; clr = 1; cyc();
        oc = 1; tgt = 1; cyc();
        chk("R6 trip wins loop", {7'd0, loop_en}, 8'd0);
        chk("R6 trip wins st", {4'd0, st}, 8'h1);
        oc = 0; tgt = 1; cyc();
        chk("R6 flags discarded", {7'd0, loop_en}, 8'd0);
        clr = 1; cyc();
        chk("R6 full handshake", {7'd0, loop_en}, 8'd1);
    endtask

    task automatic t_warn();
        zone = 3'd1; cyc();
        chk("R8 zone1 loop", {7'd0, loop_en}, 8'd1);
        chk("R8 zone1 st", {4'd0, st}, 8'h4);
        zone = 3'd2; cyc();
        chk("R8 zone2 loop", {7'd0, loop_en}, 8'd1);
        zone = 3'd0; cyc();
        chk("R10 warn sticky", {4'd0, st}, 8'h4);
        clr = 1; cyc();
        chk("R10 warn cleared", {4'd0, st}, 8'h0);
    endtask

    task automatic t_open_load();
        ol = 1; cyc();
        chk("R9 ol st", {4'd0, st}, 8'h8);
        chk("R9 ol loop", {7'd0, loop_en}, 8'd1);
        ol = 0; clr = 1; cyc();
        chk("R9 ol cleared", {4'd0, st}, 8'h0);
    endtask

    task automatic t_inactive();
        hs = 0; oc = 1; zone = 3'd4; ol = 1; cyc();
        chk("R4 no supply loop", {7'd0, loop_en}, 8'd1);
        chk("R4 no supply st", {4'd0, st}, 8'h0);
        hs = 1; chg = 0; cyc();
        chk("R4 discharge loop", {7'd0, loop_en}, 8'd1);
        chk("R4 discharge st", {4'd0, st}, 8'h0);
        oc = 0; zone = 3'd0; ol = 0; chg = 1; cyc();
    endtask

    task automatic t_pwm();
        pwm_req = 1; hs = 1; #1;
        chk("R11 blocked", {7'd0, pwm_en}, 8'd0);
        hs = 0; #1;
        chk("R11 pass", {7'd0, pwm_en}, 8'd1);
        pwm_req = 0; #1;
        chk("R11 no req", {7'd0, pwm_en}, 8'd0);
        hs = 1; cyc();
    endtask

    task automatic t_disable();
        oc = 1; cyc();
        oc = 0; tgt = 1; cyc();
        chk("R12 locked", {7'd0, loop_en}, 8'd0);
        ec_en = 0; cyc();
        chk("R12 disabled", {7'd0, loop_en}, 8'd0);
        ec_en = 1; cyc();
        chk("R12 restart no handshake", {7'd0, loop_en}, 8'd1);
        clr = 1; cyc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        cyc();
        t_reset();
        t_enable();
        t_oc_clear_ignored();
        t_ot_clear_first();
        t_same_cycle();
        t_trip_vs_strobe();
        t_warn();
        t_open_load();
        t_inactive();
        t_pwm();
        t_disable();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule